// File: doc/BRIEF.md
# Debug-Gated Fuse Secret Shadow Bank

After reset the block fetches a fixed set of secret words from a fuse array, one word per read handshake. It keeps them in shadow registers that only its own load sequencer can write. The shadowed words are assembled into three wide cipher keys. A priority select picks one key and drives it to a cipher engine. Software can read individual shadow words through a request/response port, and only a request marked trusted is served.

A debug mode input closes every path that could carry secret data. In debug mode the per-key vectors, the selected engine key, the software read data and a direct mirror of the fuse read bus all read as zero. The gating is combinational, so data is masked in the same cycle that debug rises. The engine key is gated a second time after the mux, independently of the per-key gating. Until all words are loaded, the engine key is zero and software reads are refused.

Top module: `fuse_key_bank`

## Requirements
- R1: After reset release, `fuse_req_o` is high and `fuse_addr_o` starts at 0. The address advances by one after each cycle with `fuse_valid_i` high, through word 17. `load_done_o` rises and `fuse_req_o` falls on the clock edge that captures word 17.
- R2: While `load_done_o` is low, `key_o` is zero. A software read gets zero data with `sw_err_o` high.
- R3: Key k is the concatenation of shadow words 6k to 6k+5. Word 6k occupies bits 191:160 and word 6k+5 occupies bits 31:0.
- R4: `key_sel_i` bit 1 set selects key 2. Otherwise bit 0 set selects key 1. Otherwise key 0 is selected.
- R5: A trusted read (`sw_trusted_i`=1) of address 0..17, outside debug and after load, returns in the next cycle with `sw_rvalid_o`=1, `sw_err_o`=0 and the shadow word in `sw_rdata_o`. Each response lasts one cycle.
- R6: An untrusted read returns in the next cycle with `sw_rvalid_o`=1, `sw_err_o`=1 and zero data.
- R7: A read of an address of 18 or above returns zero data with `sw_err_o`=1.
- R8: While `debug_mode_i` is high, `key_o` is zero for every select value, starting in the same cycle that debug rises.
- R9: A read requested while `debug_mode_i` is high is refused with `sw_err_o`=1. `sw_rdata_o` reads zero whenever `debug_mode_i` is high, including a response already registered.
- R10: `fuse_peek_o` equals `fuse_rdata_i` while `fuse_valid_i` is high and debug is low. In every other case it is zero.
- R11: After `load_done_o` rises, further `fuse_valid_i` pulses leave all keys and shadow words unchanged, and `load_done_o` stays high.
- R12: A load performed with debug high still completes. The keys become visible once debug falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| debug_mode_i | input | 1 | Debug mode; masks all secret outputs |
| fuse_req_o | output | 1 | Fuse word read request |
| fuse_addr_o | output | 5 | Fuse word address |
| fuse_valid_i | input | 1 | Fuse read data valid strobe |
| fuse_rdata_i | input | 32 | Fuse read data |
| fuse_peek_o | output | 32 | Gated mirror of the fuse read bus |
| load_done_o | output | 1 | All fuse words captured |
| sw_req_i | input | 1 | Software read request |
| sw_trusted_i | input | 1 | Request comes from trusted software |
| sw_addr_i | input | 5 | Shadow word index |
| sw_rvalid_o | output | 1 | Read response valid |
| sw_err_o | output | 1 | Read refused |
| sw_rdata_o | output | 32 | Read data |
| key_sel_i | input | 2 | Engine key select |
| key_o | output | 192 | Key to the cipher engine |

## Verification
The bench uses the default build: three keys of six 32-bit words. This puts every key boundary, the last valid address (17) and the out-of-range addresses 18 and 31 within reach. The fuse model answers each request after a latency of 3 cycles, so the sequencer's wait state and its address hold are both exercised. Every shadow word carries a distinct value computed from its address, so a wrong word order inside a key, or a wrong key picked by the select, shows up as a mismatch.

// File: rtl/fkb_pkg.sv
package fkb_pkg;
  typedef enum logic {
    LD_FETCH = 1'b0,
    LD_DONE  = 1'b1
  } ld_state_e;
endpackage

// File: rtl/fkb_loader.sv
module fkb_loader
  import fkb_pkg::*;
#(
  parameter int NUM_WORDS = 18,
  parameter int WORD_W    = 32,
  localparam int AW       = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fuse_valid_i,
  input  logic [WORD_W-1:0] fuse_rdata_i,
  output logic              fuse_req_o,
  output logic [AW-1:0]     fuse_addr_o,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              done_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_WORDS - 1);

  ld_state_e     state_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LD_FETCH;
      addr_q  <= '0;
    end else if (state_q == LD_FETCH && fuse_valid_i) begin
      if (addr_q == LAST) state_q <= LD_DONE;
      else                addr_q  <= addr_q + AW'(1);
    end
  end

  assign fuse_req_o  = (state_q == LD_FETCH);
  assign fuse_addr_o = addr_q;
  // only the sequencer may write shadow storage
  assign we_o        = (state_q == LD_FETCH) && fuse_valid_i;
  assign waddr_o     = addr_q;
  assign wdata_o     = fuse_rdata_i;
  assign done_o      = (state_q == LD_DONE);
endmodule

// File: rtl/fkb_shadow.sv
module fkb_shadow #(
  parameter int NUM_KEYS      = 3,
  parameter int WORDS_PER_KEY = 6,
  parameter int WORD_W        = 32,
  localparam int NUM_WORDS    = NUM_KEYS * WORDS_PER_KEY,
  localparam int AW           = $clog2(NUM_WORDS),
  localparam int KEY_W        = WORDS_PER_KEY * WORD_W
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                debug_mode_i,
  input  logic                                we_i,
  input  logic [AW-1:0]                       waddr_i,
  input  logic [WORD_W-1:0]                   wdata_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]    words_o,
  output logic [NUM_KEYS-1:0][KEY_W-1:0]      key_vec_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign words_o = mem_q;

  // per-key assembly, lowest word index in the top slice; every key gated
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    logic [KEY_W-1:0] raw;
    always_comb begin
      raw = '0;
      for (int w = 0; w < WORDS_PER_KEY; w++) begin
        raw[(WORDS_PER_KEY-1-w)*WORD_W +: WORD_W] = mem_q[k*WORDS_PER_KEY + w];
      end
    end
    assign key_vec_o[k] = debug_mode_i ? '0 : raw;
  end
endmodule

// File: rtl/fkb_key_mux.sv
module fkb_key_mux #(
  parameter int NUM_KEYS = 3,
  parameter int KEY_W    = 192,
  localparam int SEL_W   = (NUM_KEYS > 1) ? NUM_KEYS - 1 : 1,
  localparam int KIW     = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic                           debug_mode_i,
  input  logic                           done_i,
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [NUM_KEYS-1:0][KEY_W-1:0] key_vec_i,
  output logic [KEY_W-1:0]               key_o
);
  logic [KIW-1:0]   pick;
  logic [KEY_W-1:0] chosen;

  // highest set select bit wins; none set picks key 0
  always_comb begin
    pick = '0;
    for (int b = 0; b < SEL_W; b++) begin
      if (sel_i[b] && (b + 1) < NUM_KEYS) pick = KIW'(b + 1);
    end
  end

  assign chosen = key_vec_i[pick];
  // second gate after the mux, independent of the per-key gates
  assign key_o  = (debug_mode_i || !done_i) ? '0 : chosen;
endmodule

// File: rtl/fkb_sw_port.sv
module fkb_sw_port #(
  parameter int NUM_WORDS = 18,
  parameter int WORD_W    = 32,
  localparam int AW       = $clog2(NUM_WORDS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             debug_mode_i,
  input  logic                             done_i,
  input  logic                             req_i,
  input  logic                             trusted_i,
  input  logic [AW-1:0]                    addr_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_i,
  output logic                             rvalid_o,
  output logic                             err_o,
  output logic [WORD_W-1:0]                rdata_o
);
  logic              in_range;
  logic              grant;
  logic [WORD_W-1:0] word_sel;
  logic              rvalid_q, err_q;
  logic [WORD_W-1:0] data_q;

  assign in_range = ({1'b0, addr_i} < (AW+1)'(NUM_WORDS));
  assign grant    = trusted_i && !debug_mode_i && done_i && in_range;
  assign word_sel = in_range ? words_i[addr_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      rvalid_q <= req_i;
      err_q    <= req_i && !grant;
      data_q   <= (req_i && grant) ? word_sel : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
  // registered data still masked the moment debug rises
  assign rdata_o  = debug_mode_i ? '0 : data_q;
endmodule

// File: rtl/fuse_key_bank.sv
module fuse_key_bank #(
  parameter int NUM_KEYS      = 3,
  parameter int WORDS_PER_KEY = 6,
  parameter int WORD_W        = 32,
  localparam int NUM_WORDS    = NUM_KEYS * WORDS_PER_KEY,
  localparam int AW           = $clog2(NUM_WORDS),
  localparam int KEY_W        = WORDS_PER_KEY * WORD_W,
  localparam int SEL_W        = (NUM_KEYS > 1) ? NUM_KEYS - 1 : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              debug_mode_i,
  output logic              fuse_req_o,
  output logic [AW-1:0]     fuse_addr_o,
  input  logic              fuse_valid_i,
  input  logic [WORD_W-1:0] fuse_rdata_i,
  output logic [WORD_W-1:0] fuse_peek_o,
  output logic              load_done_o,
  input  logic              sw_req_i,
  input  logic              sw_trusted_i,
  input  logic [AW-1:0]     sw_addr_i,
  output logic              sw_rvalid_o,
  output logic              sw_err_o,
  output logic [WORD_W-1:0] sw_rdata_o,
  input  logic [SEL_W-1:0]  key_sel_i,
  output logic [KEY_W-1:0]  key_o
);
  logic                             we;
  logic [AW-1:0]                    waddr;
  logic [WORD_W-1:0]                wdata;
  logic                             done;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;
  logic [NUM_KEYS-1:0][KEY_W-1:0]   key_vec;

  fkb_loader #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_loader (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fuse_valid_i (fuse_valid_i),
    .fuse_rdata_i (fuse_rdata_i),
    .fuse_req_o   (fuse_req_o),
    .fuse_addr_o  (fuse_addr_o),
    .we_o         (we),
    .waddr_o      (waddr),
    .wdata_o      (wdata),
    .done_o       (done)
  );

  fkb_shadow #(.NUM_KEYS(NUM_KEYS), .WORDS_PER_KEY(WORDS_PER_KEY), .WORD_W(WORD_W)) u_shadow (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .debug_mode_i (debug_mode_i),
    .we_i         (we),
    .waddr_i      (waddr),
    .wdata_i      (wdata),
    .words_o      (words),
    .key_vec_o    (key_vec)
  );

  fkb_key_mux #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)) u_key_mux (
    .debug_mode_i (debug_mode_i),
    .done_i       (done),
    .sel_i        (key_sel_i),
    .key_vec_i    (key_vec),
    .key_o        (key_o)
  );

  fkb_sw_port #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_sw_port (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .debug_mode_i (debug_mode_i),
    .done_i       (done),
    .req_i        (sw_req_i),
    .trusted_i    (sw_trusted_i),
    .addr_i       (sw_addr_i),
    .words_i      (words),
    .rvalid_o     (sw_rvalid_o),
    .err_o        (sw_err_o),
    .rdata_o      (sw_rdata_o)
  );

  // raw fuse bus mirror, closed in debug
  assign fuse_peek_o = (fuse_valid_i && !debug_mode_i) ? fuse_rdata_i : '0;
  assign load_done_o = done;
endmodule

// File: rtl/fkb_checker.sv
module fkb_checker #(
  parameter int NUM_WORDS = 18,
  parameter int WORD_W    = 32,
  parameter int KEY_W     = 192,
  localparam int AW       = $clog2(NUM_WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              debug_mode_i,
  input logic              fuse_req_o,
  input logic [AW-1:0]     fuse_addr_o,
  input logic              fuse_valid_i,
  input logic [WORD_W-1:0] fuse_peek_o,
  input logic              load_done_o,
  input logic              sw_req_i,
  input logic              sw_trusted_i,
  input logic              sw_rvalid_o,
  input logic              sw_err_o,
  input logic [WORD_W-1:0] sw_rdata_o,
  input logic [KEY_W-1:0]  key_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_WORDS - 1);

  p_addr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_req_o && fuse_valid_i && fuse_addr_o != LAST |=> fuse_addr_o == $past(fuse_addr_o) + AW'(1));
  p_addr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_req_o && !fuse_valid_i |=> $stable(fuse_addr_o) && fuse_req_o);
  p_last_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_req_o && fuse_valid_i && fuse_addr_o == LAST |=> load_done_o && !fuse_req_o);
  p_nodone_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_done_o |-> key_o == '0);
  p_resp_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_i |=> sw_rvalid_o);
  p_resp_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_req_i |=> !sw_rvalid_o && !sw_err_o);
  p_untrusted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_i && !sw_trusted_i |=> sw_err_o && sw_rdata_o == '0);
  p_dbg_key_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_mode_i |-> key_o == '0);
  p_dbg_deny_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_i && debug_mode_i |=> sw_err_o);
  p_dbg_rdata_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_mode_i |-> sw_rdata_o == '0);
  p_dbg_peek_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_mode_i || !fuse_valid_i) |-> fuse_peek_o == '0);
  p_done_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |=> load_done_o && !fuse_req_o);
endmodule

bind fuse_key_bank fkb_checker #(
  .NUM_WORDS (NUM_WORDS),
  .WORD_W    (WORD_W),
  .KEY_W     (KEY_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .debug_mode_i (debug_mode_i),
  .fuse_req_o   (fuse_req_o),
  .fuse_addr_o  (fuse_addr_o),
  .fuse_valid_i (fuse_valid_i),
  .fuse_peek_o  (fuse_peek_o),
  .load_done_o  (load_done_o),
  .sw_req_i     (sw_req_i),
  .sw_trusted_i (sw_trusted_i),
  .sw_rvalid_o  (sw_rvalid_o),
  .sw_err_o     (sw_err_o),
  .sw_rdata_o   (sw_rdata_o),
  .key_o        (key_o)
);

// File: tb/fuse_key_bank_tb.sv
module fuse_key_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FUSE_LAT   = 3;
  localparam int NW         = 18;
  localparam int WPK        = 6;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         debug_mode_i = 1'b0;
  logic         fuse_req_o;
  logic [4:0]   fuse_addr_o;
  logic         fuse_valid_i;
  logic [31:0]  fuse_rdata_i;
  logic [31:0]  fuse_peek_o;
  logic         load_done_o;
  logic         sw_req_i = 1'b0, sw_trusted_i = 1'b0;
  logic [4:0]   sw_addr_i = '0;
  logic         sw_rvalid_o, sw_err_o;
  logic [31:0]  sw_rdata_o;
  logic [1:0]   key_sel_i = '0;
  logic [191:0] key_o;

  logic         mdl_valid;
  logic [31:0]  mdl_data;
  int           mdl_cnt;
  logic         inj_valid = 1'b0;
  logic [31:0]  inj_data = '0;

  int n_checks = 0, n_fail = 0, exp_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_key_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .debug_mode_i(debug_mode_i),
    .fuse_req_o(fuse_req_o), .fuse_addr_o(fuse_addr_o),
    .fuse_valid_i(fuse_valid_i), .fuse_rdata_i(fuse_rdata_i),
    .fuse_peek_o(fuse_peek_o), .load_done_o(load_done_o),
    .sw_req_i(sw_req_i), .sw_trusted_i(sw_trusted_i), .sw_addr_i(sw_addr_i),
    .sw_rvalid_o(sw_rvalid_o), .sw_err_o(sw_err_o), .sw_rdata_o(sw_rdata_o),
    .key_sel_i(key_sel_i), .key_o(key_o)
  );

  function automatic logic [31:0] fdat(input int a);
    return 32'hC3A5_0001 ^ (32'(a) << 20) ^ (32'(a) * 32'h0000_1F3D);
  endfunction

  function automatic logic [191:0] kexp(input int k);
    logic [191:0] r = '0;
    for (int w = 0; w < WPK; w++) r[(WPK-1-w)*32 +: 32] = fdat(k*WPK + w);
    return r;
  endfunction

  // fuse macro model: answers a held request after FUSE_LAT cycles
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mdl_cnt <= 0; mdl_valid <= 1'b0; mdl_data <= '0;
    end else if (fuse_req_o && !mdl_valid) begin
      if (mdl_cnt == FUSE_LAT - 1) begin
        mdl_cnt <= 0; mdl_valid <= 1'b1; mdl_data <= fdat(int'(fuse_addr_o));
      end else mdl_cnt <= mdl_cnt + 1;
    end else mdl_valid <= 1'b0;
  end

  assign fuse_valid_i = mdl_valid | inj_valid;
  assign fuse_rdata_i = inj_valid ? inj_data : mdl_data;

  task automatic chk(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // load order and fuse mirror monitor
  always @(negedge clk) begin
    if (rst_ni && mdl_valid && !inj_valid && fuse_req_o) begin
      chk(fuse_addr_o == 5'(exp_idx), "R1 load address order", 192'(fuse_addr_o), 192'(exp_idx));
      chk(fuse_peek_o == (debug_mode_i ? 32'h0 : fuse_rdata_i), "R10 fuse mirror",
          192'(fuse_peek_o), 192'(debug_mode_i ? 32'h0 : fuse_rdata_i));
      if (exp_idx == NW - 1) chk(!load_done_o, "R1 done not early", 192'(load_done_o), 192'(0));
      exp_idx++;
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    report();
  end

  task automatic wait_done(input string tag);
    int guard = 0;
    while (!load_done_o && guard < 500) begin @(negedge clk); guard++; end
    chk(load_done_o && !fuse_req_o, tag, 192'({load_done_o, fuse_req_o}), 192'(2'b10));
    chk(exp_idx == NW, {tag, " word count"}, 192'(exp_idx), 192'(NW));
  endtask

  // fields: sel[8:7] dbg[6] trusted[5] addr[4:0]
  localparam logic [8:0] VEC [12] = '{
    {2'b00, 1'b0, 1'b1, 5'd0},  {2'b01, 1'b0, 1'b1, 5'd7},
    {2'b10, 1'b0, 1'b1, 5'd17}, {2'b11, 1'b0, 1'b1, 5'd12},
    {2'b01, 1'b0, 1'b0, 5'd3},  {2'b10, 1'b1, 1'b1, 5'd4},
    {2'b00, 1'b1, 1'b0, 5'd4},  {2'b11, 1'b1, 1'b1, 5'd13},
    {2'b00, 1'b0, 1'b1, 5'd18}, {2'b01, 1'b0, 1'b1, 5'd31},
    {2'b10, 1'b0, 1'b0, 5'd17}, {2'b00, 1'b0, 1'b1, 5'd5}
  };

  initial begin
    // reset state
    repeat (2) @(negedge clk);
    chk(!load_done_o && key_o == '0 && !sw_rvalid_o, "R2 reset state",
        192'({load_done_o, sw_rvalid_o}), 192'(0));
    rst_ni = 1'b1;
    @(negedge clk);
    chk(fuse_req_o && fuse_addr_o == 5'd0, "R1 first request", 192'({fuse_req_o, fuse_addr_o}), 192'({1'b1, 5'd0}));
    // read before load completes
    sw_req_i = 1'b1; sw_trusted_i = 1'b1; sw_addr_i = 5'd0;
    @(negedge clk);
    sw_req_i = 1'b0;
    chk(sw_rvalid_o && sw_err_o && sw_rdata_o == '0, "R2 read before load",
        192'({sw_rvalid_o, sw_err_o, sw_rdata_o}), 192'({2'b11, 32'h0}));
    chk(key_o == '0, "R2 key before load", key_o, '0);
    wait_done("R1 load done");

    // table walk
    foreach (VEC[i]) begin
      logic [1:0] sel = VEC[i][8:7];
      logic dbg = VEC[i][6], tr = VEC[i][5];
      logic [4:0] ad = VEC[i][4:0];
      int pick = sel[1] ? 2 : (sel[0] ? 1 : 0);
      bit ok_rd = tr && !dbg && (ad < 5'(NW));
      logic [191:0] ek = dbg ? '0 : kexp(pick);
      logic [31:0] ed = ok_rd ? fdat(int'(ad)) : 32'h0;
      key_sel_i = sel; debug_mode_i = dbg; sw_trusted_i = tr; sw_addr_i = ad; sw_req_i = 1'b1;
      #1;
      chk(key_o == ek, dbg ? "R8 key masked in debug" : "R3 R4 key layout and select", key_o, ek);
      @(negedge clk);
      sw_req_i = 1'b0;
      chk(sw_rvalid_o && sw_err_o == !ok_rd && sw_rdata_o == ed,
          dbg ? "R9 read in debug" : (!tr ? "R6 untrusted read" : (ad >= 5'(NW) ? "R7 out of range" : "R5 trusted read")),
          192'({sw_rvalid_o, sw_err_o, sw_rdata_o}), 192'({1'b1, !ok_rd, ed}));
      @(negedge clk);
      chk(!sw_rvalid_o && !sw_err_o, "R5 single-cycle response", 192'({sw_rvalid_o, sw_err_o}), 192'(0));
    end
    debug_mode_i = 1'b0;

    // debug rising over an already registered response
    sw_trusted_i = 1'b1; sw_addr_i = 5'd2; sw_req_i = 1'b1; key_sel_i = 2'b01;
    @(negedge clk);
    sw_req_i = 1'b0;
    debug_mode_i = 1'b1; #1;
    chk(sw_rdata_o == '0, "R9 registered data masked same cycle", 192'(sw_rdata_o), 192'(0));
    chk(key_o == '0, "R8 key masked same cycle", key_o, '0);
    debug_mode_i = 1'b0; #1;
    chk(sw_rdata_o == fdat(2), "R5 data after debug falls", 192'(sw_rdata_o), 192'(fdat(2)));
    chk(key_o == kexp(1), "R4 key after debug falls", key_o, kexp(1));

    // stray fuse strobes after load
    @(negedge clk);
    inj_data = 32'hDEAD_BEEF; inj_valid = 1'b1; #1;
    chk(fuse_peek_o == 32'hDEAD_BEEF, "R10 mirror follows bus", 192'(fuse_peek_o), 192'(32'hDEAD_BEEF));
    debug_mode_i = 1'b1; #1;
    chk(fuse_peek_o == '0, "R10 mirror closed in debug", 192'(fuse_peek_o), 192'(0));
    debug_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    inj_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      key_sel_i = (k == 2) ? 2'b10 : 2'(k); #1;
      chk(key_o == kexp(k), "R11 keys unchanged by stray strobes", key_o, kexp(k));
    end
    sw_addr_i = 5'd0; sw_req_i = 1'b1;
    @(negedge clk);
    sw_req_i = 1'b0;
    chk(sw_rdata_o == fdat(0) && load_done_o, "R11 shadow word unchanged", 192'(sw_rdata_o), 192'(fdat(0)));

    // load while in debug
    debug_mode_i = 1'b1;
    rst_ni = 1'b0; exp_idx = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    wait_done("R12 load under debug");
    key_sel_i = 2'b10; #1;
    chk(key_o == '0, "R12 key hidden while debug", key_o, '0);
    debug_mode_i = 1'b0; #1;
    chk(key_o == kexp(2), "R12 key after debug falls", key_o, kexp(2));

    @(negedge clk);
    report();
  end
endmodule